// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block sits on the host side of a parallel programming link to an external flash code array. On a start request it reads bytes from a local image buffer and writes them into the device one at a time. There is no address bus: the device holds its own address counter, which a low-to-high edge on the reset line clears and each pulse on the advance line steps forward. For each byte the sequencer puts the byte on the data lines and raises the program enable. It then pulses the program strobe and waits for the device to finish the write before it steps the address.

Write completion is detected in one of two ways, chosen by a parameter. The first waits for the ready/busy line to come back high. The second reads the byte that was just written until its top bit equals the top bit that was written. After the last byte, the sequencer clears the device counter again and reads the whole image back, comparing each byte. It reports a pass/fail flag and the address of the first mismatch. Two optional steps can be requested with each start: a chip erase before the writes, and lock-bit programming after a clean verify. A write that never finishes aborts the run with an error flag. Every run ends with a fixed power-down order.

Top module: `flash_prog_seq`

## Requirements
- R1: While `rst` is high and afterwards until `start`, all outputs are idle: `done`=0, `pass`=0, `err_timeout`=0, `dev_strobe_n`=1, `dev_adv`=0, `dev_rst`=0, `dev_pgm_en`=0, `dev_doe`=0, `dev_mode`=000.
- R2: A run begins by raising `dev_rst`, which clears the device address counter. The first byte is driven on `dev_dout`, with `dev_doe`=1 and mode 001 (write), at least `PW_CYC` cycles before `dev_pgm_en` rises.
- R3: Each byte receives exactly one strobe. The strobe drives `dev_strobe_n` low for `PW_CYC` cycles, comes after a gap of `PW_CYC` cycles and occurs only while `dev_pgm_en` is high. The strobe and the advance pulse never overlap.
- R4: The write pass covers min(`img_len`, 2^`ADDR_W`) bytes, starting at image address 0.
- R5: The sequencer issues no advance pulse until the current write has completed. With `POLL_MODE`=0, completion means `dev_rdy` is high. With `POLL_MODE`=1, it drives mode 010 (read) with `dev_doe`=0 and waits until `dev_din[7]` equals bit 7 of the written byte.
- R6: If a write has not completed within 2×`WRITE_CYC` cycles, the run aborts to power-down. It ends with `err_timeout`=1, `pass`=0 and `done`=1.
- R7: Verify drops `dev_pgm_en`, pulses `dev_rst` low for `PW_CYC` cycles and raises it again. It then reads every written byte in mode 010, with one advance pulse between reads.
- R8: On a verify mismatch, `mm_addr` holds the lowest mismatching address. Later mismatches do not change it.
- R9: When `erase_en` is set, `dev_strobe_n` is held low for exactly `ERASE_CYC` cycles in mode 100 (erase) with `dev_pgm_en` high, before any write strobe. Rewriting a non-blank array without an erase shows up as a mismatch.
- R10: When `lock_en` is set and verify found no mismatch, one strobe is given in mode 011 (lock). No lock strobe is given after a failed verify.
- R11: Power-down leaves `dev_adv` low and drops `dev_rst` afterwards. At the end of every run `dev_rst`=0, and `done` stays high until the next `start`.
- R12: `pass`=1 only together with `done`=1, and only if there was no mismatch and no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a run (accepted when idle) |
| erase_en | input | 1 | Erase the array before writing |
| lock_en | input | 1 | Program lock bits after a clean verify |
| img_len | input | ADDR_W+1 | Number of image bytes, at least 1 |
| img_addr | output | ADDR_W | Image buffer read address |
| img_data | input | 8 | Image byte, one cycle after `img_addr` |
| dev_dout | output | 8 | Data driven to the device |
| dev_doe | output | 1 | Data drive enable |
| dev_din | input | 8 | Data read from the device |
| dev_pgm_en | output | 1 | Program-enable level request |
| dev_rst | output | 1 | Device reset line |
| dev_adv | output | 1 | Address-advance pulse |
| dev_strobe_n | output | 1 | Program strobe, active low |
| dev_mode | output | 3 | Mode code: 000 idle, 001 write, 010 read, 011 lock, 100 erase |
| dev_rdy | input | 1 | Ready (1) / busy (0) from the device |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without mismatch or timeout |
| err_timeout | output | 1 | A write did not complete in time |
| mm_addr | output | ADDR_W | Address of the first verify mismatch |

## Verification
The assertions assume `img_len` is nonzero and that `start` is raised only while no run is active. They also assume the device never drops `dev_rdy` except just after a write strobe, so ready is high whenever an advance pulse begins in ready/busy mode. The stimulus respects all three. A bench device model goes busy only for a fixed time after each write strobe, or forever when a hang is requested. Every vector uses a length from 1 upwards, and each run is launched only after the previous `done`.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_WRITE = 3'b001,
    MD_READ  = 3'b010,
    MD_LOCK  = 3'b011,
    MD_ERASE = 3'b100
  } fps_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPEN, ST_ERASE, ST_SETUP, ST_STROBE, ST_WAIT, ST_ADV,
    ST_VRST, ST_VREAD, ST_VADV, ST_LOCK, ST_LWAIT, ST_OFF, ST_OFF2
  } fps_state_e;

endpackage

// File: rtl/fps_pulse.sv
// Timed pulse: a low gap of gap_len cycles, then act high for act_len cycles,
// then a single-cycle fin.
module fps_pulse #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [TW-1:0] gap_len,
  input  logic [TW-1:0] act_len,
  output logic          act,
  output logic          fin
);
  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_GAP  = 2'd1;
  localparam logic [1:0] PH_ACT  = 2'd2;

  logic [1:0]    ph;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
      act <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          ph  <= PH_GAP;
          cnt <= gap_len;
        end
        PH_GAP: if (cnt == TW'(1)) begin
          ph  <= PH_ACT;
          cnt <= act_len;
          act <= 1'b1;
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (cnt == TW'(1)) begin
          ph  <= PH_IDLE;
          act <= 1'b0;
          fin <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R3: a new pulse is only requested once the previous one has ended
  assert_go_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    go |-> (ph == PH_IDLE));
  // R3: pulse and gap lengths are never zero
  assert_nonzero_len_R3: assert property (@(posedge clk) disable iff (rst)
    go |-> (gap_len != '0 && act_len != '0));

endmodule

// File: rtl/fps_wait.sv
// Cycle counter for completion waits; held at zero while disabled, saturates at LIMIT.
module fps_wait #(
  parameter int TW    = 8,
  parameter int LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [TW-1:0] cnt,
  output logic          expired
);
  always_ff @(posedge clk) begin
    if (rst || !en)            cnt <= '0;
    else if (cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(LIMIT));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PW_CYC    = 4,
  parameter int WRITE_CYC = 1200,
  parameter int ERASE_CYC = 10000,
  parameter bit POLL_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              erase_en,
  input  logic              lock_en,
  input  logic [ADDR_W:0]   img_len,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [7:0]        img_data,
  output logic [7:0]        dev_dout,
  output logic              dev_doe,
  input  logic [7:0]        dev_din,
  output logic              dev_pgm_en,
  output logic              dev_rst,
  output logic              dev_adv,
  output logic              dev_strobe_n,
  output logic [2:0]        dev_mode,
  input  logic              dev_rdy,
  output logic              done,
  output logic              pass,
  output logic              err_timeout,
  output logic [ADDR_W-1:0] mm_addr
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int TO_LIMIT = 2 * WRITE_CYC;
  localparam int MIN_WAIT = PW_CYC + 3;
  localparam int TW       = $clog2(ERASE_CYC + TO_LIMIT + PW_CYC + 8);

  fps_state_e      st;
  fps_mode_e       mode_q;
  logic            go_q, pg_act, pg_fin;
  logic [TW-1:0]   act_len_q, wt_cnt;
  logic            wt_expired;
  logic [ADDR_W:0] cnt, nlen;
  logic            erase_q, lock_q, mm_seen;
  logic [7:0]      din_q;
  logic            rdy_q;
  logic            last, wr_complete, rd_bad;

  fps_pulse #(.TW(TW)) u_pulse (
    .clk(clk), .rst(rst), .go(go_q),
    .gap_len(TW'(PW_CYC)), .act_len(act_len_q),
    .act(pg_act), .fin(pg_fin)
  );

  fps_wait #(.TW(TW), .LIMIT(TO_LIMIT)) u_wait (
    .clk(clk), .rst(rst),
    .en(st == ST_WAIT || st == ST_LWAIT),
    .cnt(wt_cnt), .expired(wt_expired)
  );

  assign img_addr = cnt[ADDR_W-1:0];
  assign dev_mode = mode_q;
  assign last     = (cnt == nlen - 1'b1);
  assign rd_bad   = (din_q != img_data);

  generate
    if (POLL_MODE) begin : g_poll
      assign wr_complete = (din_q[7] == dev_dout[7]);
    end else begin : g_rdy
      assign wr_complete = rdy_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      mode_q       <= MD_IDLE;
      go_q         <= 1'b0;
      act_len_q    <= TW'(PW_CYC);
      cnt          <= '0;
      nlen         <= '0;
      erase_q      <= 1'b0;
      lock_q       <= 1'b0;
      mm_seen      <= 1'b0;
      din_q        <= '0;
      rdy_q        <= 1'b0;
      dev_dout     <= '0;
      dev_doe      <= 1'b0;
      dev_pgm_en   <= 1'b0;
      dev_rst      <= 1'b0;
      dev_adv      <= 1'b0;
      dev_strobe_n <= 1'b1;
      done         <= 1'b0;
      pass         <= 1'b0;
      err_timeout  <= 1'b0;
      mm_addr      <= '0;
    end else begin
      go_q         <= 1'b0;
      din_q        <= dev_din;
      rdy_q        <= dev_rdy;
      dev_strobe_n <= !(pg_act && (st == ST_ERASE || st == ST_STROBE || st == ST_LOCK));
      dev_adv      <= pg_act && (st == ST_ADV || st == ST_VADV);
      case (st)
        ST_IDLE: if (start) begin
          done        <= 1'b0;
          pass        <= 1'b0;
          err_timeout <= 1'b0;
          mm_seen     <= 1'b0;
          mm_addr     <= '0;
          erase_q     <= erase_en;
          lock_q      <= lock_en;
          nlen        <= (img_len > (ADDR_W+1)'(DEPTH)) ? (ADDR_W+1)'(DEPTH) : img_len;
          cnt         <= '0;
          dev_rst     <= 1'b1;
          act_len_q   <= TW'(PW_CYC);
          go_q        <= 1'b1;
          st          <= ST_OPEN;
        end
        ST_OPEN: if (pg_fin) begin
          go_q <= 1'b1;
          if (erase_q) begin
            mode_q     <= MD_ERASE;
            dev_pgm_en <= 1'b1;
            act_len_q  <= TW'(ERASE_CYC);
            st         <= ST_ERASE;
          end else begin
            mode_q  <= MD_WRITE;
            dev_doe <= 1'b1;
            st      <= ST_SETUP;
          end
        end
        ST_ERASE: if (pg_fin) begin
          dev_pgm_en <= 1'b0;
          mode_q     <= MD_WRITE;
          dev_doe    <= 1'b1;
          act_len_q  <= TW'(PW_CYC);
          go_q       <= 1'b1;
          st         <= ST_SETUP;
        end
        ST_SETUP: begin
          dev_dout <= img_data;
          if (pg_fin) begin
            dev_pgm_en <= 1'b1;
            go_q       <= 1'b1;
            st         <= ST_STROBE;
          end
        end
        ST_STROBE: if (pg_fin) begin
          if (POLL_MODE) begin
            mode_q  <= MD_READ;
            dev_doe <= 1'b0;
          end
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wt_expired) begin
            err_timeout <= 1'b1;
            st          <= ST_OFF;
          end else if (wt_cnt >= TW'(MIN_WAIT) && wr_complete) begin
            go_q <= 1'b1;
            if (last) begin
              dev_pgm_en <= 1'b0;
              mode_q     <= MD_READ;
              dev_doe    <= 1'b0;
              st         <= ST_VRST;
            end else st <= ST_ADV;
          end
        end
        ST_ADV: if (pg_fin) begin
          cnt     <= cnt + 1'b1;
          mode_q  <= MD_WRITE;
          dev_doe <= 1'b1;
          go_q    <= 1'b1;
          st      <= ST_SETUP;
        end
        ST_VRST: begin
          dev_rst <= !pg_act;
          if (pg_fin) begin
            cnt  <= '0;
            go_q <= 1'b1;
            st   <= ST_VREAD;
          end
        end
        ST_VREAD: if (pg_fin) begin
          if (rd_bad && !mm_seen) begin
            mm_seen <= 1'b1;
            mm_addr <= cnt[ADDR_W-1:0];
          end
          if (!last) begin
            go_q <= 1'b1;
            st   <= ST_VADV;
          end else if (lock_q && !mm_seen && !rd_bad) begin
            mode_q     <= MD_LOCK;
            dev_pgm_en <= 1'b1;
            go_q       <= 1'b1;
            st         <= ST_LOCK;
          end else st <= ST_OFF;
        end
        ST_VADV: if (pg_fin) begin
          cnt  <= cnt + 1'b1;
          go_q <= 1'b1;
          st   <= ST_VREAD;
        end
        ST_LOCK: if (pg_fin) st <= ST_LWAIT;
        ST_LWAIT: if (wt_cnt >= TW'(WRITE_CYC)) st <= ST_OFF;
        ST_OFF: begin
          mode_q     <= MD_IDLE;
          dev_pgm_en <= 1'b0;
          dev_doe    <= 1'b0;
          st         <= ST_OFF2;
        end
        ST_OFF2: begin
          dev_rst <= 1'b0;
          done    <= 1'b1;
          pass    <= !mm_seen && !err_timeout;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: program enable only rises for a write with the data already driven
  assert_data_before_pgm_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(dev_pgm_en) && dev_mode == MD_WRITE) |-> dev_doe);
  // R3: the strobe is only active while program enable is high
  assert_strobe_in_pgm_R3: assert property (@(posedge clk) disable iff (rst)
    !dev_strobe_n |-> dev_pgm_en);
  // R3: strobe and advance never overlap
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(dev_adv && !dev_strobe_n));
  // R5: in ready/busy mode an advance pulse starts only while the device is ready
  assert_adv_when_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (!POLL_MODE && $rose(dev_adv)) |-> rdy_q);
  // R6: a timeout never reports a pass
  assert_timeout_fails_R6: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> !pass);
  // R8: the first mismatch address is held once captured
  assert_first_mm_held_R8: assert property (@(posedge clk) disable iff (rst)
    (mm_seen && $past(mm_seen)) |-> $stable(mm_addr));
  // R11: reset line drops only with the advance line low, now and one cycle before
  assert_rst_order_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_rst) |-> (!dev_adv && !$past(dev_adv)));
  // R12: pass is only reported together with done
  assert_pass_with_done_R12: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

endmodule

// File: tb/flash_prog_seq_tb_top.sv
module fps_dev_model #(
  parameter int AW   = 6,
  parameter int BUSY = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          hang,
  input  logic [AW:0]   fa,
  input  logic [AW:0]   fb,
  input  logic          pgm_en,
  input  logic          rst_l,
  input  logic          adv,
  input  logic          strobe_n,
  input  logic [2:0]    mode,
  input  logic          doe,
  input  logic [7:0]    dout,
  output logic [7:0]    din,
  output logic          rdy,
  output int            wr_strobes,
  output int            erase_len,
  output int            short_strobes,
  output int            order_err,
  output int            adv_busy,
  output int            rst_rises,
  output logic          locked
);
  localparam int DEPTH = 1 << AW;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] acnt, wa;
  logic [7:0]    wd;
  logic [2:0]    fmode;
  logic          busy, rst_p, adv_p, stb_p, pgm_p;
  int            bcnt, lowlen;

  assign rdy = !busy;
  always_comb begin
    din = 8'h00;
    if (mode == 3'b010) din = busy ? {~wd[7], wd[6:0]} : mem[acnt];
  end

  always_ff @(posedge clk) begin
    rst_p <= rst_l; adv_p <= adv; stb_p <= strobe_n; pgm_p <= pgm_en;
    if (clr) begin
      busy <= 1'b0; wr_strobes <= 0; erase_len <= 0; short_strobes <= 0;
      order_err <= 0; adv_busy <= 0; rst_rises <= 0;
    end else begin
      if (rst_l && !rst_p) begin acnt <= '0; rst_rises <= rst_rises + 1; end
      else if (adv && !adv_p) acnt <= acnt + 1'b1;
      if (adv && !adv_p && busy) adv_busy <= adv_busy + 1;
      if (pgm_en && !pgm_p && mode == 3'b001 && !doe) order_err <= order_err + 1;
      if (!rst_l && rst_p && (adv || adv_p)) order_err <= order_err + 1;
      if (!strobe_n && stb_p) begin lowlen <= 1; fmode <= mode; wd <= dout; end
      else if (!strobe_n) lowlen <= lowlen + 1;
      if (strobe_n && !stb_p) begin
        if (fmode == 3'b001) begin
          busy <= 1'b1; bcnt <= 0; wa <= acnt; wr_strobes <= wr_strobes + 1;
          if (lowlen < 2) short_strobes <= short_strobes + 1;
        end else if (fmode == 3'b100) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
          locked <= 1'b0; erase_len <= lowlen;
        end else if (fmode == 3'b011) locked <= 1'b1;
      end else if (busy && !hang) begin
        if (bcnt == BUSY - 1) begin
          busy <= 1'b0;
          mem[wa] <= (mem[wa] & wd) ^ {7'd0, ({1'b0, wa} == fa || {1'b0, wa} == fb)};
        end else bcnt <= bcnt + 1;
      end
    end
  end
endmodule

module flash_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int PW = 2;
  localparam int WCYC = 12;
  localparam int ECYC = 30;

  typedef struct packed {
    logic [6:0] len; logic [7:0] seed; logic er; logic lk;
    logic [6:0] fa; logic [6:0] fb; logic hang;
    logic epass; logic eerr; logic [6:0] emm; logic elock;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{7'd5,   8'h11, 1'b1, 1'b0, 7'h7F, 7'h7F, 1'b0, 1'b1, 1'b0, 7'd0, 1'b0},
    '{7'd64,  8'h5A, 1'b1, 1'b1, 7'h7F, 7'h7F, 1'b0, 1'b1, 1'b0, 7'd0, 1'b1},
    '{7'd100, 8'h33, 1'b1, 1'b0, 7'h7F, 7'h7F, 1'b0, 1'b1, 1'b0, 7'd0, 1'b0},
    '{7'd10,  8'h11, 1'b1, 1'b1, 7'd7,  7'd3,  1'b0, 1'b0, 1'b0, 7'd3, 1'b0},
    '{7'd10,  8'h22, 1'b1, 1'b0, 7'd2,  7'd9,  1'b0, 1'b0, 1'b0, 7'd2, 1'b0},
    '{7'd1,   8'h55, 1'b1, 1'b1, 7'h7F, 7'h7F, 1'b0, 1'b1, 1'b0, 7'd0, 1'b1},
    '{7'd8,   8'h2A, 1'b0, 1'b0, 7'h7F, 7'h7F, 1'b0, 1'b0, 1'b0, 7'd0, 1'b1},
    '{7'd4,   8'h11, 1'b1, 1'b0, 7'h7F, 7'h7F, 1'b1, 1'b0, 1'b1, 7'd0, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, erase_en = 1'b0, lock_en = 1'b0;
  logic clr = 1'b1, hang = 1'b0;
  logic [AW:0] img_len = '0, fa = 7'h7F, fb = 7'h7F;
  logic [7:0] seed = 8'h00;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] img_byte(input logic [7:0] s, input logic [AW-1:0] a);
    return 8'({2'b00, a} * 8'd37) + s;
  endfunction

  // two sequencer instances: ready/busy (dut_i) and polling (dut_poll_i)
  logic [AW-1:0] ia [2];
  logic [7:0]    id [2], dout [2], din [2];
  logic [2:0]    mode [2];
  logic doe [2], pgm [2], drst [2], adv [2], stbn [2], rdy [2];
  logic done [2], pass [2], terr [2], lockd [2];
  logic [AW-1:0] mma [2];
  int wrs [2], elen [2], shorts [2], oerr [2], advb [2], rrise [2];

  always_ff @(posedge clk) begin
    id[0] <= img_byte(seed, ia[0]);
    id[1] <= img_byte(seed, ia[1]);
  end

  flash_prog_seq #(.ADDR_W(AW), .PW_CYC(PW), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC), .POLL_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .start(start), .erase_en(erase_en), .lock_en(lock_en), .img_len(img_len),
    .img_addr(ia[0]), .img_data(id[0]), .dev_dout(dout[0]), .dev_doe(doe[0]), .dev_din(din[0]),
    .dev_pgm_en(pgm[0]), .dev_rst(drst[0]), .dev_adv(adv[0]), .dev_strobe_n(stbn[0]), .dev_mode(mode[0]),
    .dev_rdy(rdy[0]), .done(done[0]), .pass(pass[0]), .err_timeout(terr[0]), .mm_addr(mma[0]));

  flash_prog_seq #(.ADDR_W(AW), .PW_CYC(PW), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC), .POLL_MODE(1'b1)) dut_poll_i (
    .clk(clk), .rst(rst), .start(start), .erase_en(erase_en), .lock_en(lock_en), .img_len(img_len),
    .img_addr(ia[1]), .img_data(id[1]), .dev_dout(dout[1]), .dev_doe(doe[1]), .dev_din(din[1]),
    .dev_pgm_en(pgm[1]), .dev_rst(drst[1]), .dev_adv(adv[1]), .dev_strobe_n(stbn[1]), .dev_mode(mode[1]),
    .dev_rdy(rdy[1]), .done(done[1]), .pass(pass[1]), .err_timeout(terr[1]), .mm_addr(mma[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mdl
    fps_dev_model #(.AW(AW), .BUSY(8)) mdl (
      .clk(clk), .clr(clr), .hang(hang), .fa(fa), .fb(fb), .pgm_en(pgm[g]), .rst_l(drst[g]),
      .adv(adv[g]), .strobe_n(stbn[g]), .mode(mode[g]), .doe(doe[g]), .dout(dout[g]),
      .din(din[g]), .rdy(rdy[g]), .wr_strobes(wrs[g]), .erase_len(elen[g]),
      .short_strobes(shorts[g]), .order_err(oerr[g]), .adv_busy(advb[g]),
      .rst_rises(rrise[g]), .locked(lockd[g]));
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    for (int d = 0; d < 2; d++) begin
      chk(!done[d] && !pass[d] && !terr[d], {tag, " flags idle"}, int'(done[d]), 0);
      chk(stbn[d] && !adv[d] && !drst[d] && !pgm[d] && !doe[d], {tag, " pins idle"},
          int'({stbn[d], adv[d], drst[d], pgm[d], doe[d]}), 16);
      chk(mode[d] == 3'b000, {tag, " mode idle"}, int'(mode[d]), 0);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int lim, nb;
    @(negedge clk);
    img_len = v.len; seed = v.seed; erase_en = v.er; lock_en = v.lk;
    fa = v.fa; fb = v.fb; hang = v.hang; clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lim = 0;
    while (!(done[0] && done[1]) && lim < 20000) begin @(negedge clk); lim++; end
    chk(lim < 20000, "R11 run finished (watchdog)", lim, 0);
    nb = (v.len > DEPTH) ? DEPTH : int'(v.len);
    for (int d = 0; d < 2; d++) begin
      chk(done[d] == 1'b1, "R11 done high", int'(done[d]), 1);
      chk(drst[d] == 1'b0 && adv[d] == 1'b0, "R11 reset low at end", int'(drst[d]), 0);
      chk(oerr[d] == 0, "R2/R11 data-before-enable and power-down order", oerr[d], 0);
      chk(pass[d] == v.epass, "R12 pass flag", int'(pass[d]), int'(v.epass));
      chk(terr[d] == v.eerr, "R6 timeout flag", int'(terr[d]), int'(v.eerr));
      chk(wrs[d] == (v.hang ? 1 : nb), "R3/R4 write strobe count", wrs[d], v.hang ? 1 : nb);
      chk(shorts[d] == 0, "R3 strobe width", shorts[d], 0);
      chk(advb[d] == 0, "R5 no advance while busy", advb[d], 0);
      chk(rrise[d] == (v.hang ? 1 : 2), "R7 reset rises (start and verify)", rrise[d], v.hang ? 1 : 2);
      chk(lockd[d] == v.elock, "R10 lock state", int'(lockd[d]), int'(v.elock));
      if (v.er) chk(elen[d] == ECYC, "R9 erase strobe length", elen[d], ECYC);
      if (!v.epass && !v.eerr)
        chk(mma[d] == v.emm[AW-1:0], "R8 first mismatch address", int'(mma[d]), int'(v.emm));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 after reset");
    // table walk: R4 clamp, R5 both completion methods, R6 hang, R8 first mismatch,
    // R9 missing erase (vector 6), R10 lock only after clean verify
    foreach (VECS[k]) run_vec(VECS[k]);
    // directed: start then reset in mid-run returns to idle (R1)
    @(negedge clk);
    img_len = 7'd20; erase_en = 1'b1; lock_en = 1'b0; hang = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);
    chk(pgm[0] || pgm[1] || drst[0], "R1 run active before reset", 0, 1);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 mid-run reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle("R1 idle after mid-run reset");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule